// File: doc/BRIEF.md
# Single-Precision Float to Unsigned Integer Truncating Converter

This unit turns one IEEE-754 single-precision value into an unsigned integer, always rounding toward zero. The float is taken from the low 32 bits of a wider source word. The result is either 32 or 64 bits wide. A 64-bit result is produced only when the wide-select input is set and the long-mode input says that 64-bit operation is active. Otherwise the unit acts as the 32-bit converter, and the upper half of the result is zero.

Two flags report exceptions:
- Invalid marks an input that has no unsigned representation at the chosen width. Such inputs are NaN, infinities, negatives of magnitude one or more, and values of 2^w or above. For these inputs the result is 2^w − 1.
- Inexact marks a conversion that discarded a nonzero fraction.

A quiet input forces both flags low and leaves the data result unchanged. Inputs are sampled on a clock edge, and result and flags appear registered after that edge, one cycle of latency.

Top module: `f2u_trunc_cvt`

## Requirements
- R1: Only bits [31:0] of `src_word` are converted (bit 31 sign, bits 30:23 biased exponent with bias 127, bits 22:0 fraction). The remaining source bits have no effect on any output.
- R2: A positive finite input whose truncated value fits in w bits yields that truncated value. It appears on `result` after the next rising clock edge.
- R3: `inexact` is 1 exactly when a nonzero fraction was discarded by a conversion that is not invalid. `invalid` and `inexact` are never 1 together.
- R4: An input with biased exponent 255 (NaN or infinity) is invalid. So is a negative input of magnitude 1.0 or more, and any input whose unbiased exponent is w or more. An invalid input gives `invalid`=1, `inexact`=0 and a result of 2^w − 1 in the low w bits.
- R5: The output width w is 64 when `long_mode`=1 and `wide_sel`=1, and 32 otherwise. With w=32, `result[63:32]` is zero.
- R6: With `long_mode`=0, `wide_sel` has no effect on any output.
- R7: Both signed zeros, and negative inputs of magnitude below 1.0, give result 0 with `invalid`=0. The negative inputs below 1.0 raise `inexact`.
- R8: Denormal inputs (biased exponent 0, nonzero fraction) give result 0 with `inexact`=1.
- R9: With `quiet`=1, both flags are 0 and `result` equals the value it would have with `quiet`=0.
- R10: While `rst_n` is low, `result`, `invalid` and `inexact` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_word | input | 128 | Source word; low 32 bits hold the float |
| long_mode | input | 1 | 64-bit operation is active |
| wide_sel | input | 1 | Requests a 64-bit result when long_mode is set |
| quiet | input | 1 | Suppresses both exception flags |
| result | output | 64 | Truncated unsigned integer |
| invalid | output | 1 | Input not representable at the chosen width |
| inexact | output | 1 | Nonzero fraction was discarded |

## Verification
Directed vectors probe the edges of each range:
- Signed zeros, the smallest and largest denormals, 0.5, −0.5 and −1.0 separate the zero, inexact and invalid paths around magnitude one.
- The powers 2^31, 2^32, 2^63 and 2^64, and the largest float below 2^32, find an off-by-one in the exponent limit for each width.
- The 2^32 vector is repeated with `long_mode` low and `wide_sel` high. This shows that the width select is ignored outside long mode.
- NaN under `quiet`, and the same float with garbage in the upper source bits, separate flag suppression and operand selection from the data path.

Random vectors then weight exponents near the integer range with random signs, fractions, modes and quiet settings. They cover the alignment shifter at every shift distance, against a division-based model in the bench.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

    localparam int FP_W  = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int BIAS  = 127;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_DENORM,
        CLS_NORMAL,
        CLS_SPECIAL
    } fp_class_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp_field;
        logic [MAN_W-1:0] man_field;
    } fp_fields_t;

endpackage

// File: rtl/f2u_classify.sv
module f2u_classify
    import f2u_pkg::*;
(
    input  logic [FP_W-1:0]  fp_bits,
    output logic             sign,
    output fp_class_e        cls,
    output logic [EXP_W+1:0] exp_unb,
    output logic [MAN_W:0]   sig
);
    fp_fields_t fields;
    localparam logic [EXP_W-1:0] EXP_ALL_ONES = '1;

    always_comb begin
        fields = fp_fields_t'(fp_bits);
        sign   = fields.sign;
        // unbiased exponent; msb set means negative (two's complement)
        exp_unb = {2'b00, fields.exp_field} - (EXP_W+2)'(BIAS);
        sig     = {1'b1, fields.man_field};
        if (fields.exp_field == EXP_ALL_ONES) begin
            cls = CLS_SPECIAL;
        end else if (fields.exp_field == '0) begin
            cls = (fields.man_field == '0) ? CLS_ZERO : CLS_DENORM;
        end else begin
            cls = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/f2u_align.sv
module f2u_align
    import f2u_pkg::*;
#(
    parameter int OUT_W = 64,
    localparam int SH_W  = $clog2(OUT_W),
    localparam int EXT_W = OUT_W + MAN_W
) (
    input  logic [MAN_W:0]    sig,
    input  logic [SH_W-1:0]   shamt,
    output logic [OUT_W-1:0]  whole,
    output logic              lost
);
    logic [EXT_W-1:0] ext;

    // the binary point sits MAN_W bits up from the bottom of ext
    always_comb begin
        ext   = {{(OUT_W-1){1'b0}}, sig} << shamt;
        whole = ext[EXT_W-1:MAN_W];
        lost  = |ext[MAN_W-1:0];
    end
endmodule

// File: rtl/f2u_range.sv
module f2u_range
    import f2u_pkg::*;
#(
    parameter int OUT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  fp_class_e        cls,
    input  logic             sign,
    input  logic [EXP_W+1:0] exp_unb,
    input  logic             wide,
    output logic             below_one,
    output logic             bad
);
    localparam logic [EXP_W+1:0] LIM_WIDE   = (EXP_W+2)'(OUT_W);
    localparam logic [EXP_W+1:0] LIM_NARROW = (EXP_W+2)'(NARROW_W);

    logic [EXP_W+1:0] limit;
    logic             exp_neg;

    always_comb begin
        limit     = wide ? LIM_WIDE : LIM_NARROW;
        exp_neg   = exp_unb[EXP_W+1];
        below_one = (cls == CLS_NORMAL) && exp_neg;
        unique case (cls)
            CLS_SPECIAL: bad = 1'b1;
            CLS_NORMAL:  bad = !exp_neg && (sign || (exp_unb >= limit));
            default:     bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/f2u_trunc_cvt.sv
module f2u_trunc_cvt
    import f2u_pkg::*;
#(
    parameter int SRC_W    = 128,
    parameter int OUT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_word,
    input  logic             long_mode,
    input  logic             wide_sel,
    input  logic             quiet,
    output logic [OUT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    localparam int SH_W = $clog2(OUT_W);

    typedef struct packed {
        logic [OUT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } cvt_out_t;

    logic [FP_W-1:0]  fp_bits;
    logic             sign;
    fp_class_e        cls;
    logic [EXP_W+1:0] exp_unb;
    logic [MAN_W:0]   sig;
    logic             wide;
    logic             below_one;
    logic             bad;
    logic [OUT_W-1:0] whole;
    logic             lost;
    logic [OUT_W-1:0] sat_value;
    logic [OUT_W-1:0] narrow_mask;

    cvt_out_t out_d, out_q;

    assign fp_bits = src_word[FP_W-1:0];
    assign wide    = long_mode & wide_sel;

    generate
        if (OUT_W > NARROW_W) begin : g_mask
            assign narrow_mask = {{(OUT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        end else begin : g_mask_full
            assign narrow_mask = '1;
        end
    endgenerate

    assign sat_value = wide ? {OUT_W{1'b1}} : narrow_mask;

    f2u_classify u_classify (
        .fp_bits (fp_bits),
        .sign    (sign),
        .cls     (cls),
        .exp_unb (exp_unb),
        .sig     (sig)
    );

    f2u_range #(.OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_range (
        .cls       (cls),
        .sign      (sign),
        .exp_unb   (exp_unb),
        .wide      (wide),
        .below_one (below_one),
        .bad       (bad)
    );

    f2u_align #(.OUT_W(OUT_W)) u_align (
        .sig   (sig),
        .shamt (exp_unb[SH_W-1:0]),
        .whole (whole),
        .lost  (lost)
    );

    always_comb begin
        out_d = '0;
        if (bad) begin
            out_d.value   = sat_value;
            out_d.invalid = 1'b1;
        end else begin
            unique case (cls)
                CLS_DENORM: out_d.inexact = 1'b1;
                CLS_NORMAL: begin
                    if (below_one) begin
                        out_d.inexact = 1'b1;
                    end else begin
                        out_d.value   = whole & sat_value;
                        out_d.inexact = lost;
                    end
                end
                default: out_d = '0;
            endcase
        end
        if (quiet) begin
            out_d.invalid = 1'b0;
            out_d.inexact = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result  = out_q.value;
    assign invalid = out_q.invalid;
    assign inexact = out_q.inexact;
endmodule

// File: rtl/f2u_checker.sv
module f2u_checker #(
    parameter int SRC_W    = 128,
    parameter int OUT_W    = 64,
    parameter int NARROW_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_W-1:0] src_word,
    input logic             long_mode,
    input logic             wide_sel,
    input logic             quiet,
    input logic [OUT_W-1:0] result,
    input logic             invalid,
    input logic             inexact
);
    localparam logic [OUT_W-1:0] ONES_N = OUT_W'({NARROW_W{1'b1}});

    logic [OUT_W-1:0] hi_part;
    assign hi_part = result >> NARROW_W;

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(invalid && inexact));

    assert_invalid_all_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!quiet && (src_word[30:23] == 8'hFF)) |=>
            (invalid && (result == ($past(long_mode && wide_sel) ? {OUT_W{1'b1}} : ONES_N))));

    assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(long_mode && wide_sel) |=> (hi_part == '0));

    assert_denorm_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!quiet && (src_word[30:23] == 8'h00) && (src_word[22:0] != '0)) |=>
            (inexact && !invalid && (result == '0)));

    assert_quiet_flags_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> (!invalid && !inexact));
endmodule

bind f2u_trunc_cvt f2u_checker #(
    .SRC_W(SRC_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_word  (src_word),
    .long_mode (long_mode),
    .wide_sel  (wide_sel),
    .quiet     (quiet),
    .result    (result),
    .invalid   (invalid),
    .inexact   (inexact)
);

// File: tb/f2u_trunc_cvt_test.sv
`timescale 1ns/1ps
module f2u_trunc_cvt_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src_word = '0;
    logic         long_mode = 1'b0;
    logic         wide_sel = 1'b0;
    logic         quiet = 1'b0;
    logic [63:0]  result;
    logic         invalid;
    logic         inexact;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    f2u_trunc_cvt uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_word  (src_word),
        .long_mode (long_mode),
        .wide_sel  (wide_sel),
        .quiet     (quiet),
        .result    (result),
        .invalid   (invalid),
        .inexact   (inexact)
    );

    task automatic ref_model(input logic [31:0] f, input bit wide, input bit q,
                             output logic [63:0] val, output bit inv, output bit inx);
        int          ue;
        int          w;
        logic [63:0] sig;
        logic [63:0] div;
        w   = wide ? 64 : 32;
        val = '0; inv = 0; inx = 0;
        if (f[30:23] == 8'hFF) inv = 1;
        else if (f[30:23] == 8'h00) inx = (f[22:0] != 0);
        else begin
            ue  = int'(f[30:23]) - 127;
            sig = {40'd0, 1'b1, f[22:0]};
            if (ue < 0) inx = 1;
            else if (f[31]) inv = 1;
            else if (ue >= w) inv = 1;
            else if (ue >= 23) val = sig * (64'd1 << (ue - 23));
            else begin
                div = 64'd1 << (23 - ue);
                val = sig / div;
                inx = (sig % div) != 0;
            end
        end
        if (inv) val = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        if (q) begin inv = 0; inx = 0; end
    endtask

    task automatic run_vec(input logic [127:0] src, input bit lm, input bit ws,
                           input bit q, input string tag);
        logic [63:0] ev;
        bit          ei;
        bit          ex;
        @(negedge clk);
        src_word = src; long_mode = lm; wide_sel = ws; quiet = q;
        ref_model(src[31:0], lm && ws, q, ev, ei, ex);
        @(negedge clk);
        checks++;
        if (result !== ev || invalid !== ei || inexact !== ex) begin
            failures++;
            $display("FAIL %s src=%h lm=%0b ws=%0b q=%0b actual=%h/%0b/%0b expected=%h/%0b/%0b",
                     tag, src[31:0], lm, ws, q, result, invalid, inexact, ev, ei, ex);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        src_word = {96'h0, 32'h4120_0000};
        repeat (3) @(negedge clk);
        checks++;
        if (result !== 64'd0 || invalid !== 1'b0 || inexact !== 1'b0) begin
            failures++;
            $display("FAIL R10 reset actual=%h/%0b/%0b expected=0/0/0", result, invalid, inexact);
        end
        rst_n = 1'b1;

        run_vec({96'h0, 32'h0000_0000}, 0, 0, 0, "R7 +0");
        run_vec({96'h0, 32'h8000_0000}, 1, 1, 0, "R7 -0");
        run_vec({96'h0, 32'hBF00_0000}, 1, 1, 0, "R7 -0.5");
        run_vec({96'h0, 32'h0000_0001}, 0, 0, 0, "R8 min denormal");
        run_vec({96'h0, 32'h807F_FFFF}, 1, 1, 0, "R8 neg max denormal");
        run_vec({96'h0, 32'h3F80_0000}, 0, 0, 0, "R2 1.0");
        run_vec({96'h0, 32'h3F00_0000}, 0, 0, 0, "R3 0.5");
        run_vec({96'h0, 32'h3FC0_0000}, 1, 1, 0, "R3 1.5");
        run_vec({96'h0, 32'hBF80_0000}, 0, 0, 0, "R4 -1.0");
        run_vec({96'h0, 32'h4F00_0000}, 0, 0, 0, "R2 2^31 narrow");
        run_vec({96'h0, 32'h4F7F_FFFF}, 0, 0, 0, "R2 max below 2^32");
        run_vec({96'h0, 32'h4F80_0000}, 0, 0, 0, "R4 2^32 narrow");
        run_vec({96'h0, 32'h4F80_0000}, 1, 1, 0, "R5 2^32 wide");
        run_vec({96'h0, 32'h4F80_0000}, 0, 1, 0, "R6 wide_sel ignored");
        run_vec({96'h0, 32'h4F80_0000}, 1, 0, 0, "R5 long mode narrow");
        run_vec({96'h0, 32'h5F00_0000}, 1, 1, 0, "R2 2^63 wide");
        run_vec({96'h0, 32'h5F80_0000}, 1, 1, 0, "R4 2^64 wide");
        run_vec({96'h0, 32'h7F80_0000}, 1, 1, 0, "R4 +inf");
        run_vec({96'h0, 32'hFF80_0000}, 0, 0, 0, "R4 -inf");
        run_vec({96'h0, 32'h7FC0_0001}, 1, 1, 0, "R4 NaN");
        run_vec({96'h0, 32'h7FC0_0001}, 0, 0, 1, "R9 quiet NaN");
        run_vec({96'h0, 32'h3FC0_0000}, 0, 0, 1, "R9 quiet inexact");
        run_vec({96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h4B12_3456}, 1, 1, 0, "R1 upper garbage");
        run_vec({96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h3F80_0000}, 0, 0, 0, "R1 upper ones");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] f;
            logic [7:0]  e;
            bit          lm, ws, q;
            logic [63:0] ev;
            bit          ei, ex;
            string       tag;
            e  = ($urandom % 2 == 1) ? 8'(100 + $urandom % 100) : 8'($urandom % 256);
            f  = {1'($urandom % 4 == 0), e, 23'($urandom)};
            lm = 1'($urandom); ws = 1'($urandom); q = ($urandom % 8 == 0);
            ref_model(f, lm && ws, 1'b0, ev, ei, ex);
            tag = q ? "R9 random" : (ei ? "R4 random" : (ex ? "R3 random" : "R2 random"));
            run_vec({$urandom, $urandom, $urandom, f}, lm, ws, q, tag);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule